// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory. A fast system clock oversamples the serial clock and data lines, which reach it through a two-stage synchronizer. The block finds Start and Stop conditions in the system clock domain. It shifts in bytes MSB first and compares the device-select byte against a fixed type nibble and three strap inputs. It then loads a 13-bit word address from two address bytes and acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

A persistent word-address counter is kept between transactions. A write-direction select followed by two address bytes and then a repeated Start therefore becomes a random read. A read-direction select with no address bytes returns the byte at the counter. Sequential reads advance the counter on every master ACK and wrap from the top of the 8K space to address 0. Data bytes sent in the write direction are stored in an internal array model. The model returns 0xFF for any location that has not been written. A busy flag from the external write controller makes the block refuse its device address while an internal write cycle runs.

Top module: `eeprom_link_engine`

## Requirements
- R1: A Start (SDA falling while SCL high) restarts byte reception with a new device-select byte at any point, even in the middle of a byte. A Stop (SDA rising while SCL high) returns the block to idle with SDA released.
- R2: The device-select byte carries 4'b1010 in bits 7..4, the strap inputs {A2,A1,A0} in bits 3..1 and the direction in bit 0 (1 = read). On any mismatch SDA stays released for that ACK slot and for every later byte until the next Start.
- R3: An ACK pulls SDA low from just after the falling edge of the eighth SCL clock, through the high phase of the ninth clock, and releases SDA just after the ninth falling edge.
- R4: After a write-direction select, the first address byte supplies A12..A8 in its bits 4..0 and its bits 7..5 are ignored. The second byte supplies A7..A0, and both bytes are ACKed.
- R5: Each data byte after the two address bytes in the write direction is ACKed and stored at the counter, and the counter then steps by one.
- R6: After reset SDA is released, the counter is 0 and every location reads 0xFF. A read-direction select with no address bytes returns the byte at the counter, which holds the last accessed address plus one.
- R7: During a read, a master ACK (SDA low in the ninth clock) makes the next byte follow. A master NACK ends the read with SDA released before the next Start or Stop.
- R8: The counter rolls over from 0x1FFF to 0x0000 for reads and for writes.
- R9: While the busy input is high, no device-select byte is ACKed, whatever its direction.
- R10: Two address bytes in the write direction followed by a repeated Start and a read-direction select read from the address just given.
- R11: Read data leaves MSB first, and SDA drive changes only in response to an SCL falling edge, a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Strap pins {A2,A1,A0} compared with select bits 3..1 |
| wr_busy_i | input | 1 | High while the external write controller runs a write cycle |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench writes across the top of the address space so that the counter wraps between 0x1FFF and 0. A design that stops at the top or wraps within a page reads back 0xFF where the wrapped bytes should be. A first address byte with its upper three bits set catches a decoder that takes eight bits instead of five, which would point to a location that was never written. A dummy write followed by current reads, a Start in the middle of a byte, and select bytes with the wrong strap or with busy high check that the counter persists, that the bit count resets, and that no stray ACK appears on a NACKed transfer. The ACK is sampled just before the ninth rising edge and again just after the ninth falling edge, which shows whether it was driven too late or held too long.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;
  logic scl_cur, sda_cur;

  assign scl_cur = scl_sh[SYNC_STAGES-1];
  assign sda_cur = sda_sh[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_cur;
      sda_prev <= sda_cur;
    end
  end

  assign sda_lvl  = sda_cur;
  assign scl_rise = scl_cur & ~scl_prev;
  assign scl_fall = ~scl_cur & scl_prev;
  // SCL held high across both samples, SDA moved between them
  assign start_p  = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_p   = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/eep_sparse_array.sv
`timescale 1ns/1ps
module eep_sparse_array #(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]         rhit, whit;
  logic [ENTRIES-1:0][DW-1:0] rsel;
  logic                       whit_any;
  logic [PW-1:0]              victim_q, victim_d;

  assign whit_any = |whit;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic          vld_q;
      logic [AW-1:0] tag_q;
      logic [DW-1:0] dat_q;
      logic          take;

      assign take    = we_i & (whit[g] | (~whit_any & (victim_q == PW'(g))));
      assign rhit[g] = vld_q & (tag_q == raddr_i);
      assign whit[g] = vld_q & (tag_q == waddr_i);
      assign rsel[g] = rhit[g] ? dat_q : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          tag_q <= '0;
          dat_q <= '0;
        end else if (take) begin
          vld_q <= 1'b1;
          tag_q <= waddr_i;
          dat_q <= wdata_i;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < ENTRIES; i++) rdata_o = rdata_o | rsel[i];
    if (rhit == '0) rdata_o = '1;
  end

  always_comb begin
    victim_d = victim_q;
    if (we_i && !whit_any)
      victim_d = (victim_q == PW'(ENTRIES - 1)) ? '0 : victim_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) victim_q <= '0;
    else        victim_q <= victim_d;
  end

  AST_READ_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rhit)) else $error("duplicate tag on read"); // R5
  AST_WRITE_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(whit)) else $error("duplicate tag on write"); // R5
endmodule

// File: rtl/eep_proto_ctrl.sv
`timescale 1ns/1ps
module eep_proto_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [2:0]        strap_i,
  input  logic              wr_busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              sda_oe_o
);
  localparam int HI_BITS = ADDR_W - 8;
  localparam logic [3:0] CNT_ACK = 4'd8;
  localparam logic [3:0] CNT_END = 4'd9;

  eep_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [7:0]        tx_q, tx_d;
  logic [HI_BITS-1:0] hi_q, hi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ack_q, ack_d;
  logic              txd_q, txd_d;
  logic              mack_q, mack_d;
  logic              rw_q, rw_d;
  logic              sel_match;

  assign sel_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == strap_i) && !wr_busy_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    hi_d   = hi_q;
    addr_d = addr_q;
    ack_d  = ack_q;
    txd_d  = txd_q;
    mack_d = mack_q;
    rw_d   = rw_q;
    if (start_p) begin
      st_d  = ST_DEV;
      cnt_d = '0;
      ack_d = 1'b0;
      txd_d = 1'b0;
    end else if (stop_p) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      ack_d = 1'b0;
      txd_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < CNT_ACK) sh_d = {sh_q[6:0], sda_lvl};
        else                 mack_d = sda_lvl;
        cnt_d = cnt_q + 4'd1;
      end
      if (scl_fall) begin
        if (cnt_q == CNT_ACK) begin
          txd_d = 1'b0;
          unique case (st_q)
            ST_DEV: begin
              if (sel_match) begin
                ack_d = 1'b1;
                rw_d  = sh_q[0];
              end else begin
                st_d = ST_IDLE;
              end
            end
            ST_AHI: begin
              ack_d = 1'b1;
              hi_d  = sh_q[HI_BITS-1:0];
            end
            ST_ALO: begin
              ack_d  = 1'b1;
              addr_d = {hi_q, sh_q};
            end
            ST_WDATA: begin
              ack_d  = 1'b1;
              addr_d = addr_q + ADDR_W'(1);
            end
            default: ;
          endcase
        end else if (cnt_q == CNT_END) begin
          ack_d = 1'b0;
          cnt_d = '0;
          unique case (st_q)
            ST_DEV: begin
              if (rw_q) begin
                st_d   = ST_RDATA;
                tx_d   = mem_rdata_i;
                txd_d  = ~mem_rdata_i[7];
                addr_d = addr_q + ADDR_W'(1);
              end else begin
                st_d = ST_AHI;
              end
            end
            ST_AHI:   st_d = ST_ALO;
            ST_ALO:   st_d = ST_WDATA;
            ST_RDATA: begin
              if (!mack_q) begin
                tx_d   = mem_rdata_i;
                txd_d  = ~mem_rdata_i[7];
                addr_d = addr_q + ADDR_W'(1);
              end else begin
                st_d  = ST_IDLE;
                txd_d = 1'b0;
              end
            end
            default: ;
          endcase
        end else if (st_q == ST_RDATA && cnt_q != '0) begin
          txd_d = ~tx_q[3'd7 - cnt_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
      ack_q  <= 1'b0;
      txd_q  <= 1'b0;
      mack_q <= 1'b1;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
      ack_q  <= ack_d;
      txd_q  <= txd_d;
      mack_q <= mack_d;
      rw_q   <= rw_d;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sh_q;
  assign mem_we_o    = (st_q == ST_WDATA) && scl_fall && (cnt_q == CNT_ACK);
  assign sda_oe_o    = ack_q | txd_q;

  AST_OE_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start_p || stop_p))
    else $error("SDA drive changed without a falling SCL edge"); // R11
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEV && cnt_q == CNT_ACK && scl_fall && wr_busy_i) |=> !ack_q)
    else $error("select acknowledged while busy"); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe_o)
    else $error("SDA driven while idle"); // R1
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !scl_fall && !start_p && !stop_p) |=> ack_q)
    else $error("ACK dropped inside its slot"); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDATA && cnt_q == CNT_END && scl_fall && !mack_q && addr_q == '1)
    |=> (addr_q == '0))
    else $error("counter failed to roll over"); // R8
endmodule

// File: rtl/eeprom_link_engine.sv
`timescale 1ns/1ps
module eeprom_link_engine #(
  parameter int ADDR_W        = 13,
  parameter int STORE_ENTRIES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wr_busy_i,
  output logic       sda_oe_o
);
  logic [1:0]        rst_sh_q;
  logic              rst_sync_n;
  logic              sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  eep_proto_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_p     (start_p),
    .stop_p      (stop_p),
    .strap_i     (strap_i),
    .wr_busy_i   (wr_busy_i),
    .mem_rdata_i (mem_rdata),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .sda_oe_o    (sda_oe_o)
  );

  eep_sparse_array #(.AW(ADDR_W), .DW(8), .ENTRIES(STORE_ENTRIES)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_addr),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/eeprom_link_engine_tb_top.sv
`timescale 1ns/1ps
module eeprom_link_engine_tb_top;
  localparam int Q  = 8;
  localparam int NV = 45;
  localparam logic [1:0] OP_S = 2'd0, OP_W = 2'd1, OP_R = 2'd2, OP_P = 2'd3;

  // {op, req, arg, exp}: W arg=byte exp[0]=ack; R arg[0]=master NACK exp=data
  localparam logic [21:0] VEC [NV] = '{
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd2,  8'hAA, 8'h01},  // R2 select write, strap 101
    {OP_W, 4'd4,  8'hFF, 8'h01},  // R4 upper bits junk -> A12..A8 = 1F
    {OP_W, 4'd4,  8'hFE, 8'h01},  // R4
    {OP_W, 4'd5,  8'h11, 8'h01},  // R5 at 1FFE
    {OP_W, 4'd5,  8'h22, 8'h01},  // R5 at 1FFF
    {OP_W, 4'd8,  8'h33, 8'h01},  // R8 wrapped to 0000
    {OP_W, 4'd5,  8'h44, 8'h01},  // R5 at 0001
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd6,  8'hAB, 8'h01},  // R6 current read
    {OP_R, 4'd6,  8'h01, 8'hFF},  // R6 addr 0002 unwritten
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd10, 8'hAA, 8'h01},  // R10 dummy write
    {OP_W, 4'd4,  8'h3F, 8'h01},  // R4
    {OP_W, 4'd10, 8'hFE, 8'h01},  // R10
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd10, 8'hAB, 8'h01},  // R10
    {OP_R, 4'd10, 8'h00, 8'h11},  // R10 R11 MSB first
    {OP_R, 4'd7,  8'h00, 8'h22},  // R7
    {OP_R, 4'd8,  8'h00, 8'h33},  // R8 read wrap
    {OP_R, 4'd7,  8'h01, 8'h44},  // R7 NACK ends
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd10, 8'hAA, 8'h01},  // R10
    {OP_W, 4'd4,  8'hE0, 8'h01},  // R4 junk bits only -> hi 0
    {OP_W, 4'd10, 8'h00, 8'h01},  // R10
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd6,  8'hAB, 8'h01},  // R6
    {OP_R, 4'd6,  8'h01, 8'h33},  // R6 counter at 0000
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd6,  8'hAB, 8'h01},  // R6
    {OP_R, 4'd6,  8'h01, 8'h44},  // R6 counter stepped to 0001
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd2,  8'hA8, 8'h00},  // R2 wrong strap
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_W, 4'd2,  8'hAD, 8'h00},  // R2 wrong strap, read
    {OP_P, 4'd0,  8'h00, 8'h00},
    {OP_S, 4'd0,  8'h00, 8'h00},
    {OP_P, 4'd0,  8'h00, 8'h00}
  };

  logic clk, rst_n, scl_m, sda_m, busy;
  logic sda_oe, sda_bus;
  int   checks, failures, cyc;
  logic ack, oe_mid, oe_end;
  logic [7:0] rd;

  assign sda_bus = sda_m & ~sda_oe;

  eeprom_link_engine dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .strap_i   (3'b101),
    .wr_busy_i (busy),
    .sda_oe_o  (sda_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog got=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input logic ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tick(Q);
    oe_mid = sda_oe;
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
    oe_end = sda_oe;
  endtask

  task automatic read_byte(input logic nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      rd[i] = sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0;
    sda_m = 1'b1; tick(Q);
    oe_end = sda_oe;
  endtask

  initial begin
    checks = 0; failures = 0;
    scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0, "R6 reset release", sda_oe, 0);

    // R6: fresh current read returns erased value
    start_c(); write_byte(8'hAB);
    chk(ack, "R6 select after reset", ack, 1);
    read_byte(1'b1);
    chk(rd == 8'hFF, "R6 erased data", rd, 8'hFF);
    stop_c();

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [7:0] arg, ex;
      string tag;
      op  = VEC[v][21:20];
      arg = VEC[v][15:8];
      ex  = VEC[v][7:0];
      tag = $sformatf("R%0d row %0d", VEC[v][19:16], v);
      case (op)
        OP_S: start_c();
        OP_P: stop_c();
        OP_W: begin
          write_byte(arg);
          chk(ack == ex[0], tag, ack, ex[0]);
        end
        default: begin
          read_byte(arg[0]);
          chk(rd == ex, tag, rd, ex);
          if (arg[0]) chk(oe_end == 1'b0, {tag, " R7 release"}, oe_end, 0);
        end
      endcase
    end

    // R3: ACK window edges
    start_c(); write_byte(8'hAA);
    chk(oe_mid == 1'b1, "R3 driven before ninth rise", oe_mid, 1);
    chk(ack, "R3 low in ninth high", ack, 1);
    chk(oe_end == 1'b0, "R3 released after ninth fall", oe_end, 0);
    stop_c();
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);

    // R9: busy refuses both directions
    busy = 1'b1;
    start_c(); write_byte(8'hAA);
    chk(!ack, "R9 busy write select", ack, 0);
    stop_c();
    start_c(); write_byte(8'hAB);
    chk(!ack, "R9 busy read select", ack, 0);
    stop_c();
    busy = 1'b0;
    start_c(); write_byte(8'hAB);
    chk(ack, "R9 select after busy clears", ack, 1);
    read_byte(1'b1);
    chk(rd == 8'hFF, "R9 read at 0002", rd, 8'hFF);
    stop_c();

    // R2: no ACK after mismatch until next Start
    start_c(); write_byte(8'hA8);
    chk(!ack, "R2 mismatch", ack, 0);
    write_byte(8'h00);
    chk(!ack && !oe_mid, "R2 later byte ignored", ack, 0);
    stop_c();

    // R1: Start in the middle of a byte restarts reception
    start_c(); write_byte(8'hAA); write_byte(8'h00); write_byte(8'h01);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    start_c(); write_byte(8'hAB);
    chk(ack, "R1 select after mid-byte start", ack, 1);
    read_byte(1'b1);
    chk(rd == 8'h44, "R1 read after restart", rd, 8'h44);
    stop_c();
    chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

    summary();
  end
endmodule